// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block is an 8-bit serial transmitter and receiver that shares one shift clock between its two directions. Each direction has two stages. Bytes that software writes go into a transmit buffer, which feeds a transmit shift register. Bytes taken in through the receive shift register are committed to a receive buffer. A four-address register window on the parallel bus holds the data, control, status and divisor registers. The data address is shared: a write goes to the transmit buffer and a read returns the receive buffer.

The shift clock comes from one of two sources:
- an internal divider, which is driven by the system clock or by the system clock divided by four;
- an external clock input, which is synchronised and then edge-detected.

The transmit line changes on the falling edge of the shift clock, and the receive line is sampled on the rising edge. The least significant bit goes first. If a new byte is written while a shift is still running, the clock keeps running and the next byte follows with no gap. The transmit interrupt can be taken from one of two events: the buffer becoming empty, or the shift completing. A receive interrupt marks each byte that arrives. An overrun flag records a byte that arrived while the previous one was still unread.

Top module: `sync_serial_port`

## Requirements
- R1: Control bit 6 enables synchronous operation. While it is 0, a write to the transmit buffer starts no transfer: the shift clock stays high, status reads TBE=0, TSC=1, and the transfer starts once bit 6 is set.
- R2: Register addresses are as follows. Address 0: a write loads the transmit buffer and a read returns the receive buffer. Address 1: control, with bit 0 selecting the external clock, bit 1 selecting the transmit interrupt source (1 = shift complete), bit 2 selecting the divide-by-4 prescaler, and bit 6 as in R1. Address 2: status, with bit 0 TBE, bit 1 RBF, bit 2 TSC and bit 3 overrun. Address 3: divisor n. Control and divisor read back what was written.
- R3: With the internal clock, the shift clock period is 2*(n+1)*P system clocks, where P is 1 or 4 as set by control bit 2.
- R4: Data is shifted least significant bit first. The transmit line changes only on a falling shift-clock edge and the receive line is sampled on the rising edge, so a transmit line looped back to the receive line returns the written byte.
- R5: After reset, status reads 0x05, the shift clock output and transmit line are high, and the shift clock rests high whenever TSC=1. TBE clears on a data write and sets when the buffer moves into the shift register. TSC clears when a shift starts and sets after the eighth bit.
- R6: A byte written while TSC=0 follows the current byte with no idle time, and the shift clock period stays constant across the boundary.
- R7: txIrq is a one-cycle pulse on each 0-to-1 change of the selected flag: TBE when control bit 1 is 0, and TSC when it is 1. In the TSC case, the pulse coincides with the eighth rising shift-clock edge.
- R8: rxIrq pulses once when RBF changes from 0 to 1, and a data read clears RBF.
- R9: A byte that completes while RBF=1 sets the overrun flag and overwrites the receive buffer. Any write to the status address clears the overrun flag.
- R10: With the external clock selected, bits move on the synchronised edges of extClkIn (transmit on falling, receive on rising), and sclkOut stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (a data read clears RBF) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| extClkIn | input | 1 | External shift clock |
| rxd | input | 1 | Serial receive line, synchronous to clk |
| txd | output | 1 | Serial transmit line |
| sclkOut | output | 1 | Shift clock output, idle high |
| txIrq | output | 1 | Transmit interrupt pulse |
| rxIrq | output | 1 | Receive interrupt pulse |

## Verification
The bench uses the default configuration: 8 data bits, an 8-bit divisor and a prescaler of 4. It sweeps divisors 0 to 3 with each prescaler setting, which gives shift periods from 2 to 32 clocks. Every setting runs in loopback with several byte patterns, so the period, bit order and received data are all checked against arithmetic expectations. Three dedicated sequences then cover the remaining behaviour: a back-to-back pair that also overruns, a transfer held off by the enable bit, and an externally clocked transfer with an independent receive pattern.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic loadShift;   // copy transmit buffer into transmit shift register
    logic driveBit;    // falling shift edge: present next transmit bit
    logic sampleBit;   // rising shift edge: take receive bit, advance transmit
    logic commitRx;    // eighth rising edge: move received byte to buffer
  } shiftCmd_t;

  localparam logic [1:0] ADDR_DATA   = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_DIV    = 2'd3;

  localparam int CTRL_EXT   = 0;
  localparam int CTRL_TISEL = 1;
  localparam int CTRL_PRE   = 2;
  localparam int CTRL_SYNC  = 6;
endpackage

// File: rtl/ssp_datapath.sv
module ssp_datapath import ssp_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrTxBuf,
  input  logic [DATA_W-1:0] wrData,
  input  shiftCmd_t         cmd,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rxBuf
);
  logic [DATA_W-1:0] txBuf, txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxBuf   <= '0;
      txd     <= 1'b1;
    end else begin
      if (wrTxBuf) txBuf <= wrData;
      if (cmd.loadShift) txShift <= txBuf;
      else if (cmd.sampleBit) txShift <= txShift >> 1;
      if (cmd.driveBit) txd <= txShift[0];
      if (cmd.sampleBit) rxShift <= {rxd, rxShift[DATA_W-1:1]};
      if (cmd.commitRx) rxBuf <= {rxd, rxShift[DATA_W-1:1]};
    end
  end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl import ssp_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int PRE_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncEn,
  input  logic             extSel,
  input  logic             preSel,
  input  logic             tiSel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             dataWrite,
  input  logic             dataRead,
  input  logic             statusWrite,
  input  logic             extClkIn,
  output shiftCmd_t        cmd,
  output logic             sclkOut,
  output logic             tbe,
  output logic             tsc,
  output logic             rbf,
  output logic             oe,
  output logic             active,
  output logic             txIrq,
  output logic             rxIrq
);
  localparam int CNT_W = DIV_W + $clog2(PRE_DIV) + 1;
  localparam int BIT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] baudCnt, reload;
  logic [BIT_W-1:0] bitCnt;
  logic sclkInt, extMeta, extSync, extPrev;
  logic tick, fallEv, riseEv, lastBit, startEv, chainEv;
  logic prevTbe, prevTsc, prevRbf;

  always_comb begin
    if (preSel) reload = CNT_W'((int'(divisor) + 1) * PRE_DIV - 1);
    else        reload = CNT_W'(divisor);
  end

  assign tick    = (baudCnt == '0);
  assign fallEv  = active & (extSel ? (extPrev & ~extSync) : (tick & sclkInt));
  assign riseEv  = active & (extSel ? (~extPrev & extSync) : (tick & ~sclkInt));
  assign lastBit = riseEv & (bitCnt == BIT_W'(DATA_W - 1));
  assign startEv = ~active & ~tbe & syncEn;
  assign chainEv = lastBit & ~tbe;

  assign cmd.loadShift = startEv | chainEv;
  assign cmd.driveBit  = fallEv;
  assign cmd.sampleBit = riseEv;
  assign cmd.commitRx  = lastBit;

  assign sclkOut = extSel ? 1'b1 : sclkInt;
  assign txIrq   = tiSel ? (tsc & ~prevTsc) : (tbe & ~prevTbe);
  assign rxIrq   = rbf & ~prevRbf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMeta <= 1'b1;
      extSync <= 1'b1;
      extPrev <= 1'b1;
      active  <= 1'b0;
      sclkInt <= 1'b1;
      baudCnt <= '0;
      bitCnt  <= '0;
      tbe     <= 1'b1;
      tsc     <= 1'b1;
      rbf     <= 1'b0;
      oe      <= 1'b0;
      prevTbe <= 1'b1;
      prevTsc <= 1'b1;
      prevRbf <= 1'b0;
    end else begin
      extMeta <= extClkIn;
      extSync <= extMeta;
      extPrev <= extSync;
      prevTbe <= tbe;
      prevTsc <= tsc;
      prevRbf <= rbf;

      if (startEv) begin
        active  <= 1'b1;
        bitCnt  <= '0;
        baudCnt <= reload;
        sclkInt <= 1'b1;
      end else if (active) begin
        if (!extSel) begin
          baudCnt <= tick ? reload : baudCnt - 1'b1;
          if (tick) sclkInt <= ~sclkInt;
        end
        if (lastBit) bitCnt <= '0;
        else if (riseEv) bitCnt <= bitCnt + 1'b1;
        if (lastBit && tbe) begin
          active  <= 1'b0;
          sclkInt <= 1'b1;
        end
      end

      if (dataWrite) tbe <= 1'b0;
      else if (cmd.loadShift) tbe <= 1'b1;

      if (startEv) tsc <= 1'b0;
      else if (lastBit && tbe) tsc <= 1'b1;

      if (lastBit) rbf <= 1'b1;
      else if (dataRead) rbf <= 1'b0;

      if (lastBit && rbf) oe <= 1'b1;
      else if (statusWrite) oe <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port import ssp_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              extClkIn,
  input  logic              rxd,
  output logic              txd,
  output logic              sclkOut,
  output logic              txIrq,
  output logic              rxIrq
);
  logic [DATA_W-1:0] ctrlReg, rxBuf;
  logic [DIV_W-1:0]  divReg;
  logic dataWrite, dataRead, statusWrite;
  logic tbeFlag, tscFlag, rbfFlag, oeFlag, shiftActive;
  logic extSel, tiSel;
  shiftCmd_t cmd;

  assign dataWrite   = busWr && (busAddr == ADDR_DATA);
  assign dataRead    = busRd && (busAddr == ADDR_DATA);
  assign statusWrite = busWr && (busAddr == ADDR_STATUS);
  assign extSel      = ctrlReg[CTRL_EXT];
  assign tiSel       = ctrlReg[CTRL_TISEL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      divReg  <= '0;
    end else if (busWr) begin
      if (busAddr == ADDR_CTRL) ctrlReg <= busWdata;
      if (busAddr == ADDR_DIV)  divReg  <= busWdata[DIV_W-1:0];
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_DATA:   busRdata = rxBuf;
      ADDR_CTRL:   busRdata = ctrlReg;
      ADDR_STATUS: busRdata = DATA_W'({oeFlag, tscFlag, rbfFlag, tbeFlag});
      default:     busRdata = DATA_W'(divReg);
    endcase
  end

  ssp_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .syncEn(ctrlReg[CTRL_SYNC]), .extSel(extSel), .preSel(ctrlReg[CTRL_PRE]),
    .tiSel(tiSel), .divisor(divReg),
    .dataWrite(dataWrite), .dataRead(dataRead), .statusWrite(statusWrite),
    .extClkIn(extClkIn), .cmd(cmd), .sclkOut(sclkOut),
    .tbe(tbeFlag), .tsc(tscFlag), .rbf(rbfFlag), .oe(oeFlag),
    .active(shiftActive), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  ssp_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .wrTxBuf(dataWrite), .wrData(busWdata),
    .cmd(cmd), .rxd(rxd), .txd(txd), .rxBuf(rxBuf)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] busAddr,
  input logic       busWr,
  input logic       sclkOut,
  input logic       txd,
  input logic       txIrq,
  input logic       tbe,
  input logic       tsc,
  input logic       rbf,
  input logic       oe,
  input logic       active,
  input logic       extSel,
  input logic       tiSel
);
  // R5
  sclk_rest_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    tsc |-> sclkOut);

  // R4
  txd_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!extSel && !$stable(txd)) |-> $fell(sclkOut));

  // R9
  overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oe) |-> $past(rbf));

  // R7
  tsc_irq_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && tiSel) |-> !active);

  // R5
  tbe_clear_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd0) |=> !tbe);
endmodule

bind sync_serial_port ssp_checker i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .sclkOut(sclkOut), .txd(txd), .txIrq(txIrq),
  .tbe(tbeFlag), .tsc(tscFlag), .rbf(rbfFlag), .oe(oeFlag),
  .active(shiftActive), .extSel(extSel), .tiSel(tiSel)
);

// File: tb/test_sync_serial_port.sv
`timescale 1ns/1ps
module test_sync_serial_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic extClk = 1'b1, benchRx = 1'b0, loopMode = 1'b1;
  logic txd, sclkOut, txIrq, rxIrq, rxdLine;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign rxdLine = loopMode ? txd : benchRx;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .extClkIn(extClk), .rxd(rxdLine),
    .txd(txd), .sclkOut(sclkOut), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  // Monitor, sampled away from the active edge
  int cyc = 0, firstFall, lastFall, minPer, maxPer, fallCount, capCount;
  int txIrqCount, txIrqCyc, rxIrqCount, lastRiseCyc;
  logic [15:0] capBits;
  logic sclkPrev = 1'b1;

  task automatic clearMon();
    firstFall = -1; lastFall = -1; minPer = 1 << 20; maxPer = 0;
    fallCount = 0; capCount = 0; txIrqCount = 0; txIrqCyc = -1;
    rxIrqCount = 0; lastRiseCyc = -1; capBits = '0;
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sclkPrev && !sclkOut) begin
      if (lastFall >= 0) begin
        if (cyc - lastFall < minPer) minPer = cyc - lastFall;
        if (cyc - lastFall > maxPer) maxPer = cyc - lastFall;
      end else firstFall = cyc;
      lastFall = cyc;
      fallCount = fallCount + 1;
    end
    if (!sclkPrev && sclkOut) begin
      capBits = {txd, capBits[15:1]};
      capCount = capCount + 1;
      lastRiseCyc = cyc;
    end
    if (txIrq) begin txIrqCount = txIrqCount + 1; txIrqCyc = cyc; end
    if (rxIrq) rxIrqCount = rxIrqCount + 1;
    sclkPrev = sclkOut;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1 busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1; #0.5 d = busRdata;
    @(posedge clk); #1 busRd = 1'b0;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    do busRead(2'd2, s); while ((s & 8'h05) != 8'h05);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, pat;
    logic [7:0] extCap;
    clearMon();
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R5 reset state
    busRead(2'd2, rd);
    chk("R5 reset status", rd, 8'h05);
    chk("R5 reset sclkOut", sclkOut, 1);
    chk("R5 reset txd", txd, 1);

    // R2 readback
    busWrite(2'd3, 8'hC3); busRead(2'd3, rd); chk("R2 divisor readback", rd, 8'hC3);
    busWrite(2'd1, 8'h46); busRead(2'd1, rd); chk("R2 control readback", rd, 8'h46);

    // Sweep: prescaler x divisor x pattern, loopback
    for (int pre = 0; pre < 2; pre++) begin
      for (int dv = 0; dv < 4; dv++) begin
        for (int k = 0; k < 4; k++) begin
          int expPer;
          logic ti;
          ti = (k == 3);
          case (k)
            0: pat = 8'h00;
            1: pat = 8'hFF;
            2: pat = 8'hA5;
            default: pat = 8'h5A ^ 8'(dv * 16 + pre);
          endcase
          expPer = 2 * (dv + 1) * (pre ? 4 : 1);
          busWrite(2'd3, 8'(dv));
          busWrite(2'd1, 8'h40 | 8'(pre << 2) | 8'(ti << 1));
          clearMon();
          busWrite(2'd0, pat);
          waitIdle();
          chk("R4 transmitted byte LSB first", capBits[15:8], pat);
          chk("R4 bit count", capCount, 8);
          chk("R3 min period", minPer, expPer);
          chk("R3 max period", maxPer, expPer);
          chk("R7 tx irq count", txIrqCount, 1);
          if (ti) chk("R7 irq at eighth rise", txIrqCyc, lastRiseCyc);
          else    chk("R7 irq before first fall", int'(txIrqCyc < firstFall), 1);
          busRead(2'd2, rd); chk("R5 R8 status after transfer", rd, 8'h07);
          chk("R8 rx irq count", rxIrqCount, 1);
          busRead(2'd0, rd); chk("R4 loopback data", rd, pat);
          busRead(2'd2, rd); chk("R8 read clears RBF", rd, 8'h05);
        end
      end
    end

    // R6 back-to-back, R9 overrun
    busWrite(2'd3, 8'd1);
    busWrite(2'd1, 8'h40);
    clearMon();
    busWrite(2'd0, 8'h3C);
    do busRead(2'd2, rd); while (rd[0] != 1'b1);
    busWrite(2'd0, 8'hC1);
    waitIdle();
    chk("R6 sixteen bits", capCount, 16);
    chk("R6 both bytes in order", capBits, 16'hC13C);
    chk("R6 min period", minPer, 4);
    chk("R6 max period no gap", maxPer, 4);
    chk("R7 two TBE pulses", txIrqCount, 2);
    chk("R8 single RBF rise", rxIrqCount, 1);
    busRead(2'd2, rd); chk("R9 overrun status", rd, 8'h0F);
    busRead(2'd0, rd); chk("R9 buffer overwritten", rd, 8'hC1);
    busWrite(2'd2, 8'h00);
    busRead(2'd2, rd); chk("R9 status write clears overrun", rd, 8'h05);

    // R1 enable bit
    busWrite(2'd1, 8'h00);
    clearMon();
    busWrite(2'd0, 8'h96);
    repeat (40) @(negedge clk);
    busRead(2'd2, rd); chk("R1 disabled status", rd, 8'h04);
    chk("R1 no clock while disabled", fallCount, 0);
    busWrite(2'd1, 8'h40);
    waitIdle();
    chk("R1 starts when enabled", capBits[15:8], 8'h96);
    busRead(2'd0, rd); chk("R1 received after enable", rd, 8'h96);

    // R10 external clock
    loopMode = 1'b0;
    busWrite(2'd1, 8'h41);
    clearMon();
    busWrite(2'd0, 8'hB4);
    repeat (4) @(negedge clk);
    pat = 8'h6D;
    extCap = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); extClk = 1'b0; benchRx = pat[i];
      repeat (6) @(negedge clk);
      extCap[i] = txd;
      extClk = 1'b1;
      repeat (6) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R10 external transmit byte", extCap, 8'hB4);
    chk("R10 sclkOut held high", fallCount, 0);
    busRead(2'd2, rd); chk("R10 status after external transfer", rd, 8'h07);
    busRead(2'd0, rd); chk("R10 external receive byte", rd, 8'h6D);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule